// File: doc/BRIEF.md
# Wavelet Transform Sequencer

This block is the slave-side controller of a one-dimensional wavelet transform engine. A master scheduler asks it to run one transform. The sequencer stores the transform length and the direction (forward or inverse), then pulls samples from the scheduler one at a time. Each sample is checked with a parity bit and then acknowledged or refused. The scheduler resends any refused sample.

While samples arrive, the sequencer counts them and drives the datapath strobes:
- a sample-load strobe with the accepted word;
- two single-cycle gate pulses that switch the delay line to mirrored input at the left and right edges;
- an output strobe for each produced coefficient;
- a coefficient bank select that follows the stored direction.

After the last sample, the block runs four more steps on its own with no handshake to flush the filter. It then pulses end-of-data and drops busy in the same cycle.

Top module: `xform_seq`

## Requirements
- R1: Out of reset, busy_o, dreq_o, ack_o, nack_o, in_en_o, gate1_o, gate2_o, out_en_o and eod_o are all low.
- R2: A start_i seen at a clock edge while idle, with size_i of at least MIN_SIZE (8), begins a transform, and busy_o is high from the next cycle. A start_i seen while busy_o is high, or with size_i below MIN_SIZE, is ignored: busy_o stays as it was and the running transform keeps its length and direction.
- R3: size_i and dir_i are stored when start_i is accepted. coef_sel_o equals the stored dir_i (0 = forward, 1 = inverse) and stays constant for as long as busy_o is high.
- R4: dreq_o is high only while busy_o is high, fewer than N samples have been accepted, and neither ack_o nor nack_o is high in that cycle. Once N samples are accepted, dreq_o stays low.
- R5: A sample is taken at an edge where dreq_o and dvalid_i are both high. par_i must equal the XOR of all bits of data_i. A good sample gives a one-cycle ack_o with in_en_o, and data_o carries the word in that cycle. A bad sample gives a one-cycle nack_o only; it does not advance the count.
- R6: gate1_o is a one-cycle pulse that coincides with the ack_o of the 4th accepted sample. It occurs once per transform.
- R7: gate2_o is a one-cycle pulse that coincides with the ack_o of the N-th accepted sample. It occurs once per transform.
- R8: out_en_o pulses once for each count value from 5 to N+4, which gives exactly N pulses per transform:
  - the first pulse comes with the ack_o of the 5th sample;
  - one pulse comes with each later ack_o;
  - four more pulses follow in the four consecutive cycles after the N-th ack_o cycle.
- R9: eod_o is a one-cycle pulse in the cycle right after the last out_en_o pulse, which is 5 cycles after the N-th ack_o. busy_o is low in that same cycle, and a new start_i is accepted from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transform request from the scheduler |
| dir_i | input | 1 | Direction with the request: 0 forward, 1 inverse |
| size_i | input | SIZE_W | Transform length N with the request |
| dvalid_i | input | 1 | Scheduler presents a sample |
| data_i | input | DATA_W | Sample word |
| par_i | input | 1 | Parity of data_i (XOR of its bits) |
| busy_o | output | 1 | Transform in progress |
| dreq_o | output | 1 | Sample requested |
| ack_o | output | 1 | Last sample accepted |
| nack_o | output | 1 | Last sample refused, resend |
| in_en_o | output | 1 | Load strobe for data_o |
| data_o | output | DATA_W | Accepted sample to the datapath |
| gate1_o | output | 1 | Left-edge mirror gate pulse |
| gate2_o | output | 1 | Right-edge mirror gate pulse |
| out_en_o | output | 1 | Coefficient output strobe |
| coef_sel_o | output | 1 | Coefficient bank select (0 forward, 1 inverse) |
| eod_o | output | 1 | End-of-data pulse |

## Verification
If the state machine or the sample count goes wrong, the gate pulses land on the wrong ack_o. gate1_o then misses the 4th acceptance and gate2_o misses the N-th. The same fault changes how many out_en_o strobes arrive before and after the last sample. A flush that ends early or late moves eod_o away from its fixed five-cycle distance after the last ack_o. A lost length or direction shows up at once as a changed coef_sel_o or as a wrong strobe total. A refused sample that still advances the count moves gate1_o, and it does so within the same transform.

// File: rtl/xform_seq.sv
module xform_seq #(
  parameter int SIZE_W   = 10,
  parameter int DATA_W   = 16,
  parameter int MIN_SIZE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              dvalid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic              busy_o,
  output logic              dreq_o,
  output logic              ack_o,
  output logic              nack_o,
  output logic              in_en_o,
  output logic [DATA_W-1:0] data_o,
  output logic              gate1_o,
  output logic              gate2_o,
  output logic              out_en_o,
  output logic              coef_sel_o,
  output logic              eod_o
);
  localparam int CNT_W    = SIZE_W + 1;
  localparam int EDGE_CNT = 4;
  localparam int TAIL     = 4;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_LEFT, S_STEADY, S_FLUSH} st_t;

  st_t              st;
  logic [SIZE_W-1:0] n_q;
  logic              dir_q;
  logic [CNT_W-1:0]  cnt;

  wire [CNT_W-1:0] n_ext    = {1'b0, n_q};
  wire [CNT_W-1:0] last_cnt = n_ext + CNT_W'(TAIL);
  wire [CNT_W-1:0] cnt_nx   = cnt + 1'b1;
  wire take       = dreq_o & dvalid_i;
  wire good       = take & ((^data_i) == par_i);
  wire bad        = take & ~good;
  wire flush_step = (st == S_FLUSH) && (cnt != last_cnt);
  wire step       = good | flush_step;
  wire go         = (st == S_IDLE) && start_i && (size_i >= SIZE_W'(MIN_SIZE));

  assign busy_o     = (st != S_IDLE);
  assign dreq_o     = ((st == S_LOAD) || (st == S_STEADY)) && !ack_o && !nack_o;
  assign coef_sel_o = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      n_q   <= '0;
      dir_q <= 1'b0;
      cnt   <= '0;
    end else begin
      if (go) begin
        n_q   <= size_i;
        dir_q <= dir_i;
        cnt   <= '0;
      end else if (step) begin
        cnt <= cnt_nx;
      end
      case (st)
        S_IDLE:   if (go) st <= S_LOAD;
        S_LOAD:   if (good && cnt_nx == CNT_W'(EDGE_CNT)) st <= S_LEFT;
        S_LEFT:   st <= S_STEADY;
        S_STEADY: if (good && cnt_nx == n_ext) st <= S_FLUSH;
        S_FLUSH:  if (cnt == last_cnt) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_o    <= 1'b0;
      nack_o   <= 1'b0;
      in_en_o  <= 1'b0;
      data_o   <= '0;
      gate1_o  <= 1'b0;
      gate2_o  <= 1'b0;
      out_en_o <= 1'b0;
      eod_o    <= 1'b0;
    end else begin
      ack_o    <= good;
      nack_o   <= bad;
      in_en_o  <= good;
      if (good) data_o <= data_i;
      gate1_o  <= good && (cnt_nx == CNT_W'(EDGE_CNT));
      gate2_o  <= good && (cnt_nx == n_ext);
      out_en_o <= step && (cnt_nx >= CNT_W'(EDGE_CNT + 1));
      eod_o    <= (st == S_FLUSH) && (cnt == last_cnt);
    end
  end
endmodule

// File: rtl/xform_seq_chk.sv
module xform_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic dvalid_i,
  input logic busy_o,
  input logic dreq_o,
  input logic ack_o,
  input logic nack_o,
  input logic gate1_o,
  input logic gate2_o,
  input logic out_en_o,
  input logic coef_sel_o,
  input logic eod_o
);
  // R5
  ack_nack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && nack_o));
  // R5
  reply_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o || nack_o) |-> $past(dreq_o && dvalid_i));
  // R6
  gate1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate1_o |=> !gate1_o);
  // R7
  gate_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate1_o || gate2_o) |-> ack_o);
  // R9
  eod_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eod_o |-> (!busy_o && $past(out_en_o)));
  // R3
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(coef_sel_o));
  // R4
  dreq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_o |-> busy_o);
endmodule

bind xform_seq xform_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dvalid_i(dvalid_i), .busy_o(busy_o),
  .dreq_o(dreq_o), .ack_o(ack_o), .nack_o(nack_o), .gate1_o(gate1_o),
  .gate2_o(gate2_o), .out_en_o(out_en_o), .coef_sel_o(coef_sel_o),
  .eod_o(eod_o)
);

// File: tb/xform_seq_bench.sv
module xform_seq_bench;
  localparam int SW = 10;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, dir_i = 1'b0, dvalid_i = 1'b0, par_i = 1'b0;
  logic [SW-1:0] size_i = '0;
  logic [DW-1:0] data_i = '0;
  logic busy_o, dreq_o, ack_o, nack_o, in_en_o, gate1_o, gate2_o, out_en_o, coef_sel_o, eod_o;
  logic [DW-1:0] data_o;

  xform_seq u_xform_seq (.*);

  always #5 clk = ~clk;

  int runs = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  bit mon_on = 0;
  int cyc, acc, nk, n_in, n_g1, n_g2, n_oe, n_eod, g1_acc, g2_acc, first_oe_acc, oe_free;
  int last_ack, eod_cyc, eod_busy, coef_bad, data_bad, dreq_late, cur_size;
  bit cur_dir;
  logic [DW-1:0] exp_data;

  always @(negedge clk) if (mon_on) begin
    cyc++;
    if (ack_o) begin acc++; last_ack = cyc; end
    if (nack_o) nk++;
    if (in_en_o) begin n_in++; if (data_o !== exp_data) data_bad++; end
    if (gate1_o) begin n_g1++; g1_acc = ack_o ? acc : -1; end
    if (gate2_o) begin n_g2++; g2_acc = ack_o ? acc : -1; end
    if (out_en_o) begin
      n_oe++;
      if (n_oe == 1) first_oe_acc = ack_o ? acc : -1;
      if (!ack_o) oe_free++;
    end
    if (eod_o) begin n_eod++; eod_cyc = cyc; eod_busy = busy_o; end
    if (busy_o && coef_sel_o !== cur_dir) coef_bad++;
    if (dreq_o && acc >= cur_size) dreq_late++;
  end

  task automatic send(input logic [DW-1:0] d, input bit corrupt);
    do @(negedge clk); while (!dreq_o);
    dvalid_i = 1'b1;
    data_i   = d;
    par_i    = (^d) ^ corrupt;
    if (!corrupt) exp_data = d;
    @(posedge clk); #1;
    dvalid_i = 1'b0;
    if (corrupt) chk(nack_o && !ack_o && !in_en_o, "R5 nack on bad parity", int'(nack_o), 1);
    else         chk(ack_o && !nack_o, "R5 ack on good parity", int'(ack_o), 1);
  endtask

  task automatic test_reset();
    chk(!busy_o && !dreq_o && !ack_o && !nack_o, "R1 reset handshake", int'(busy_o), 0);
    chk(!in_en_o && !gate1_o && !gate2_o && !out_en_o && !eod_o, "R1 reset strobes", int'(out_en_o), 0);
  endtask

  task automatic test_short_size();
    @(negedge clk); start_i = 1'b1; size_i = SW'(4); dir_i = 1'b0;
    @(posedge clk); #1; start_i = 1'b0;
    chk(!busy_o && !dreq_o, "R2 short size ignored", int'(busy_o), 0);
  endtask

  task automatic run_xform(input int n, input bit dir, input int nack_pos, input bit poke);
    cyc = 0; acc = 0; nk = 0; n_in = 0; n_g1 = 0; n_g2 = 0; n_oe = 0; n_eod = 0;
    g1_acc = 0; g2_acc = 0; first_oe_acc = 0; oe_free = 0; last_ack = 0; eod_cyc = 0;
    eod_busy = 0; coef_bad = 0; data_bad = 0; dreq_late = 0; cur_size = n; cur_dir = dir;
    @(negedge clk); start_i = 1'b1; size_i = SW'(n); dir_i = dir; mon_on = 1;
    @(posedge clk); #1; start_i = 1'b0;
    chk(busy_o, "R2 busy after start", int'(busy_o), 1);
    chk(coef_sel_o == dir, "R3 bank select", int'(coef_sel_o), int'(dir));
    for (int i = 1; i <= n; i++) begin
      if (i == nack_pos) send(DW'(i * 77 + 3), 1'b1);
      if (poke && i == 6) begin
        @(negedge clk); start_i = 1'b1; size_i = SW'(n + 8); dir_i = ~dir;
        @(posedge clk); #1; start_i = 1'b0;
      end
      send(DW'(i * 37 + n) ^ DW'({dir, 15'd0}), 1'b0);
    end
    for (int k = 0; k < 40 && n_eod == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    mon_on = 0;
    chk(n_in == n, "R5 accepted samples", n_in, n);
    chk(nk == (nack_pos != 0 ? 1 : 0), "R5 nack count", nk, nack_pos != 0 ? 1 : 0);
    chk(data_bad == 0, "R5 data_o word", data_bad, 0);
    chk(n_g1 == 1 && g1_acc == 4, "R6 left gate on 4th ack", g1_acc, 4);
    chk(n_g2 == 1 && g2_acc == n, "R7 right gate on last ack", g2_acc, n);
    chk(n_oe == n, "R8 output strobe total", n_oe, n);
    chk(first_oe_acc == 5, "R8 first output strobe", first_oe_acc, 5);
    chk(oe_free == 4, "R8 flush strobes", oe_free, 4);
    chk(n_eod == 1 && eod_busy == 0, "R9 eod pulse busy low", n_eod, 1);
    chk(eod_cyc - last_ack == 5, "R9 eod distance", eod_cyc - last_ack, 5);
    chk(coef_bad == 0, "R3 bank held", coef_bad, 0);
    chk(dreq_late == 0, "R4 no request after N", dreq_late, 0);
    chk(!busy_o && !dreq_o, "R9 idle after run", int'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; test_reset();
    @(negedge clk); rst_n = 1'b1;
    test_short_size();
    run_xform(8, 1'b0, 0, 1'b0);
    run_xform(12, 1'b1, 2, 1'b0);
    run_xform(16, 1'b0, 7, 1'b1);
    run_xform(9, 1'b1, 0, 1'b1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule